// File: doc/BRIEF.md
# Clock Fan-Out Bank Select and Reference-Loss Controller

This block holds the digital control of a zero-delay clock fan-out buffer. It takes a reference clock, a clock from a phase-locked loop and a two-bit mode select. From these it drives two banks of clock outputs and one feedback output that returns to the loop. The mode select sets which banks are enabled and whether the outputs carry the loop clock or the reference itself. The reference-passthrough mode is a test mode, and it also stops the loop.

A free-running sampling clock watches the reference for rising edges. If no edge is seen for a set number of sampling cycles, the block enters power-down. In power-down every output enable drops and the loop is stopped. The next detected edge ends power-down. The loop then has a relock interval before the banks are enabled again. This wait does not apply in passthrough mode. The analog loop, the pad drivers and the pulls are outside the block and appear only as enable and select signals. A disabled output is held low, which models the pull-down on an undriven pad. Clock selection uses a plain multiplexer.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: With `mode_sel` = 2'b00, both bank enables are low, the feedback output is enabled and follows `pll_clk`, and `pll_run` is high while not in power-down.
- R2: With `mode_sel` = 2'b01, once the loop has locked, bank A is enabled, bank B is disabled, and bank A carries `pll_clk`.
- R3: With `mode_sel` = 2'b10, both banks and the feedback output carry `ref_clk` directly and `pll_run` is low. The banks are enabled at once when not in power-down, with no relock wait.
- R4: With `mode_sel` = 2'b11, once the loop has locked, both banks are enabled and carry `pll_clk`.
- R5: `fb_oe` is high exactly when `pwr_down` is low, in every mode and during the relock wait.
- R6: Once `TIMEOUT_CYC` sampling cycles pass with no detected rising edge of the reference, `pwr_down` goes high. While `pwr_down` is high, every output enable and `pll_run` are low.
- R7: Rising edges of `ref_clk` pass through a two-flop synchronizer and an edge detector. A rising edge seen while in power-down clears `pwr_down` on the third sampling edge after the reference rises.
- R8: After `pwr_down` falls, or after leaving mode 2'b10 for a loop mode, the bank enables stay low for `LOCK_CYC` sampling cycles of continuous loop operation, then rise as the mode selects.
- R9: A disabled output is held at 0. An enabled output equals the selected source clock.
- R10: While `rst_n` is low, `pwr_down` is high and `bank_a_oe`, `bank_b_oe`, `fb_oe` and `pll_run` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Free-running sampling clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock |
| pll_clk | input | 1 | Clock from the phase-locked loop |
| mode_sel | input | 2 | Mode select (pads pulled up, so an open pin reads 2'b11) |
| bank_a_clk | output | NUM_A | Bank A clock outputs |
| bank_b_clk | output | NUM_B | Bank B clock outputs |
| fb_clk | output | 1 | Feedback clock output to the loop |
| bank_a_oe | output | 1 | Shared enable of bank A |
| bank_b_oe | output | 1 | Shared enable of bank B |
| fb_oe | output | 1 | Enable of the feedback output |
| pll_run | output | 1 | Loop run request (low means shut down) |
| pwr_down | output | 1 | Power-down state |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 12 and `LOCK_CYC` = 5, and it runs the reference with a four-cycle period. Because the timeout is well above the reference period, regular edges never trip power-down. Because it is also short, stopping the reference reaches power-down within a few dozen cycles. The short lock wait makes it possible to count the relock window edge by edge, both after power-down ends and after leaving passthrough mode. All four modes, including passthrough, are visited in one run.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_A_ONLY = 2'b01,
    MODE_PASS   = 2'b10,
    MODE_ALL    = 2'b11
  } mode_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic pass;
  } route_t;

  function automatic route_t decode_mode(input logic [1:0] code);
    route_t r;
    r = '0;
    unique case (mode_e'(code))
      MODE_IDLE:   r = '{a_en: 1'b0, b_en: 1'b0, pass: 1'b0};
      MODE_A_ONLY: r = '{a_en: 1'b1, b_en: 1'b0, pass: 1'b0};
      MODE_PASS:   r = '{a_en: 1'b1, b_en: 1'b1, pass: 1'b1};
      MODE_ALL:    r = '{a_en: 1'b1, b_en: 1'b1, pass: 1'b0};
      default:     r = '0;
    endcase
    return r;
  endfunction

  function automatic int cnt_bits(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cfc_mode_decode.sv
module cfc_mode_decode
  import cfc_pkg::*;
(
  input  logic [1:0] mode_sel,
  output route_t     route
);

  always_comb begin
    route = decode_mode(mode_sel);
  end

endmodule

// File: rtl/cfc_ref_watch.sv
module cfc_ref_watch
  import cfc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic samp_clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic ref_edge,
  output logic pwr_down
);

  localparam int CW = cnt_bits(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          sync_q1;
  logic          sync_q2;
  logic          prev_q;
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync_q1 <= ref_clk;
      sync_q2 <= sync_q1;
      prev_q  <= sync_q2;
    end
  end

  assign ref_edge = sync_q2 & ~prev_q;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      pwr_down  <= 1'b1;
    end else if (ref_edge) begin
      quiet_cnt <= '0;
      pwr_down  <= 1'b0;
    end else if (!pwr_down) begin
      if (quiet_cnt == LAST) begin
        quiet_cnt <= '0;
        pwr_down  <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfc_lock_timer.sv
module cfc_lock_timer
  import cfc_pkg::*;
#(
  parameter int LOCK_CYC = 8
) (
  input  logic samp_clk,
  input  logic rst_n,
  input  logic hold,
  output logic locked
);

  localparam int LW = cnt_bits(LOCK_CYC);
  localparam logic [LW-1:0] LAST = LW'(LOCK_CYC - 1);

  logic [LW-1:0] wait_cnt;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      locked   <= 1'b0;
    end else if (hold) begin
      wait_cnt <= '0;
      locked   <= 1'b0;
    end else if (!locked) begin
      if (wait_cnt == LAST) begin
        locked <= 1'b1;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfc_fanout.sv
module cfc_fanout #(
  parameter int NUM_A = 4,
  parameter int NUM_B = 4
) (
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic             pass,
  input  logic             a_oe,
  input  logic             b_oe,
  input  logic             f_oe,
  output logic [NUM_A-1:0] a_clk,
  output logic [NUM_B-1:0] b_clk,
  output logic             f_clk
);

  logic src_clk;

  assign src_clk = pass ? ref_clk : pll_clk;
  assign f_clk   = src_clk & f_oe;

  for (genvar i = 0; i < NUM_A; i++) begin : g_bank_a
    assign a_clk[i] = src_clk & a_oe;
  end

  for (genvar j = 0; j < NUM_B; j++) begin : g_bank_b
    assign b_clk[j] = src_clk & b_oe;
  end

endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import cfc_pkg::*;
#(
  parameter int NUM_A       = 4,
  parameter int NUM_B       = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int LOCK_CYC    = 8
) (
  input  logic             samp_clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic [1:0]       mode_sel,
  output logic [NUM_A-1:0] bank_a_clk,
  output logic [NUM_B-1:0] bank_b_clk,
  output logic             fb_clk,
  output logic             bank_a_oe,
  output logic             bank_b_oe,
  output logic             fb_oe,
  output logic             pll_run,
  output logic             pwr_down
);

  route_t route;
  logic   ref_edge;
  logic   pll_hold;
  logic   locked;
  logic   out_ok;

  cfc_mode_decode u_decode (
    .mode_sel (mode_sel),
    .route    (route)
  );

  cfc_ref_watch #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_watch (
    .samp_clk (samp_clk),
    .rst_n    (rst_n),
    .ref_clk  (ref_clk),
    .ref_edge (ref_edge),
    .pwr_down (pwr_down)
  );

  assign pll_hold = pwr_down | route.pass;
  assign pll_run  = ~pll_hold;

  cfc_lock_timer #(
    .LOCK_CYC (LOCK_CYC)
  ) u_lock (
    .samp_clk (samp_clk),
    .rst_n    (rst_n),
    .hold     (pll_hold),
    .locked   (locked)
  );

  assign out_ok    = ~pwr_down & (locked | route.pass);
  assign bank_a_oe = out_ok & route.a_en;
  assign bank_b_oe = out_ok & route.b_en;
  assign fb_oe     = ~pwr_down;

  cfc_fanout #(
    .NUM_A (NUM_A),
    .NUM_B (NUM_B)
  ) u_fanout (
    .ref_clk (ref_clk),
    .pll_clk (pll_clk),
    .pass    (route.pass),
    .a_oe    (bank_a_oe),
    .b_oe    (bank_b_oe),
    .f_oe    (fb_oe),
    .a_clk   (bank_a_clk),
    .b_clk   (bank_b_clk),
    .f_clk   (fb_clk)
  );

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker
  import cfc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input logic       samp_clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       ref_edge,
  input logic       pwr_down,
  input logic       bank_a_oe,
  input logic       bank_b_oe,
  input logic       fb_oe,
  input logic       pll_run
);

  localparam int IW = cnt_bits(TIMEOUT_CYC);
  localparam logic [IW-1:0] SAT = IW'(TIMEOUT_CYC);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (ref_edge) begin
      idle_cnt <= '0;
    end else if (idle_cnt != SAT) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  a_r6_pd_quiets_all: assert property (@(posedge samp_clk) disable iff (!rst_n)
    pwr_down |-> (!bank_a_oe && !bank_b_oe && !fb_oe && !pll_run));

  a_r6_timeout_reached: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (idle_cnt == SAT) |-> pwr_down);

  a_r7_edge_wakes: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (pwr_down && ref_edge) |=> !pwr_down);

  a_r5_fb_tracks_pd: assert property (@(posedge samp_clk) disable iff (!rst_n)
    fb_oe != pwr_down);

  a_r3_pass_stops_pll: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> !pll_run);

  a_r1_idle_banks_off: assert property (@(posedge samp_clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (!bank_a_oe && !bank_b_oe));

  a_r2_b_implies_a: assert property (@(posedge samp_clk) disable iff (!rst_n)
    bank_b_oe |-> bank_a_oe);

  a_r8_wake_waits: assert property (@(posedge samp_clk) disable iff (!rst_n)
    ($fell(pwr_down) && mode_sel != 2'b10) |-> (!bank_a_oe && !bank_b_oe));

endmodule

bind clk_fanout_ctrl cfc_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_cfc_checker (
  .samp_clk  (samp_clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .ref_edge  (ref_edge),
  .pwr_down  (pwr_down),
  .bank_a_oe (bank_a_oe),
  .bank_b_oe (bank_b_oe),
  .fb_oe     (fb_oe),
  .pll_run   (pll_run)
);

// File: tb/clk_fanout_ctrl_bench.sv
`timescale 1ns/1ps
module clk_fanout_ctrl_bench;

  localparam int TO = 12;
  localparam int LK = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic [1:0] sel = 2'b11;
  logic [3:0] a_clk, b_clk;
  logic       fb_clk, a_oe, b_oe, fb_oe, pll_en, pd;

  int    checks = 0;
  int    fails = 0;
  string tag = "R10";
  bit    ref_run = 1'b0;
  bit    cmp_on = 1'b0;
  int    ref_ph = 0;

  // behavioural reference model state
  int m_s1 = 0, m_s2 = 0, m_sp = 0;
  int m_gap = 0;
  int m_pd = 1;
  int m_run = 0;

  clk_fanout_ctrl #(
    .NUM_A (4), .NUM_B (4), .TIMEOUT_CYC (TO), .LOCK_CYC (LK)
  ) u_clk_fanout_ctrl (
    .samp_clk (clk), .rst_n (rst_n), .ref_clk (ref_clk), .pll_clk (pll_clk),
    .mode_sel (sel), .bank_a_clk (a_clk), .bank_b_clk (b_clk), .fb_clk (fb_clk),
    .bank_a_oe (a_oe), .bank_b_oe (b_oe), .fb_oe (fb_oe), .pll_run (pll_en),
    .pwr_down (pd)
  );

  always #2.5 clk = ~clk;

  // stimulus clocks change 1 ns after each sampling edge
  always @(posedge clk) begin
    #1;
    pll_clk = ~pll_clk;
    if (ref_run) begin
      ref_ph = ref_ph + 1;
      ref_clk = ref_ph[1];
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // reference model: edge seen two samples late, gap counter, run counter
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_sp = 0; m_gap = 0; m_pd = 1; m_run = 0;
    end else begin
      bit seen;
      seen = (m_s2 == 1) && (m_sp == 0);
      if (m_pd == 1 || sel == 2'b10) m_run = 0;
      else m_run = m_run + 1;
      if (seen) begin
        m_gap = 0;
        m_pd = 0;
      end else begin
        m_gap = m_gap + 1;
        if (m_gap >= TO) m_pd = 1;
      end
      m_sp = m_s2;
      m_s2 = m_s1;
      m_s1 = int'(ref_clk);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit e_pass, e_ok, e_a, e_b, e_fb, e_pll, e_src;
      e_pass = (sel == 2'b10);
      e_ok   = (m_pd == 0) && (m_run >= LK || e_pass);
      e_a    = e_ok && (sel != 2'b00);
      e_b    = e_ok && sel[1];
      e_fb   = (m_pd == 0);
      e_pll  = (m_pd == 0) && !e_pass;
      e_src  = e_pass ? ref_clk : pll_clk;
      chk(pd == m_pd[0], {tag, " pwr_down"}, pd, m_pd);
      chk(a_oe == e_a, {tag, " bank_a_oe"}, a_oe, e_a);
      chk(b_oe == e_b, {tag, " bank_b_oe"}, b_oe, e_b);
      chk(fb_oe == e_fb, {tag, " fb_oe"}, fb_oe, e_fb);
      chk(pll_en == e_pll, {tag, " pll_run"}, pll_en, e_pll);
      chk(a_clk == {4{e_src & e_a}}, {tag, " bank_a_clk"}, a_clk, {4{e_src & e_a}});
      chk(b_clk == {4{e_src & e_b}}, {tag, " bank_b_clk"}, b_clk, {4{e_src & e_b}});
      chk(fb_clk == (e_src & e_fb), {tag, " fb_clk"}, fb_clk, e_src & e_fb);
    end
  end

  task automatic wait_pd(input bit val, input int limit, output int took);
    took = 0;
    while (pd != val && took < limit) begin
      @(negedge clk);
      took++;
    end
  endtask

  initial begin
    int took;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(pd == 1'b1, "R10 pwr_down in reset", pd, 1);
    chk({a_oe, b_oe, fb_oe, pll_en} == 4'b0, "R10 enables in reset", {a_oe, b_oe, fb_oe, pll_en}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    ref_run = 1'b1;
    tag = "R7";
    wait_pd(1'b0, 40, took);
    chk(pd == 1'b0, "R7 first edge ends power-down", pd, 0);
    // R8 relock after wake, R5 feedback driven meanwhile
    chk(a_oe == 1'b0, "R8 bank A held after wake", a_oe, 0);
    chk(fb_oe == 1'b1, "R5 feedback on during relock", fb_oe, 1);
    repeat (LK - 1) @(negedge clk);
    chk(a_oe == 1'b0, "R8 bank A held at last relock cycle", a_oe, 0);
    @(negedge clk);
    chk(a_oe == 1'b1 && b_oe == 1'b1, "R8 banks on after relock", {a_oe, b_oe}, 3);
    tag = "R4";
    repeat (3) @(negedge clk);
    chk(a_clk == {4{pll_clk}}, "R4 bank A carries loop clock", a_clk, {4{pll_clk}});
    chk(b_clk == {4{pll_clk}}, "R4 bank B carries loop clock", b_clk, {4{pll_clk}});
    tag = "R1";
    sel = 2'b00;
    @(negedge clk);
    chk({a_oe, b_oe} == 2'b00, "R1 banks off", {a_oe, b_oe}, 0);
    chk(pll_en == 1'b1 && fb_oe == 1'b1, "R1 loop and feedback on", {pll_en, fb_oe}, 3);
    chk(fb_clk == pll_clk, "R1 feedback follows loop", fb_clk, pll_clk);
    @(negedge clk);
    chk(a_clk == 4'b0 && b_clk == 4'b0, "R9 disabled banks low", {a_clk, b_clk}, 0);
    tag = "R2";
    sel = 2'b01;
    repeat (2) @(negedge clk);
    chk(a_oe == 1'b1 && b_oe == 1'b0, "R2 only bank A", {a_oe, b_oe}, 2);
    chk(b_clk == 4'b0, "R9 bank B low", b_clk, 0);
    tag = "R3";
    sel = 2'b10;
    @(negedge clk);
    chk(a_oe == 1'b1 && b_oe == 1'b1, "R3 banks on at once", {a_oe, b_oe}, 3);
    chk(pll_en == 1'b0, "R3 loop stopped", pll_en, 0);
    repeat (6) begin
      @(negedge clk);
      chk(a_clk == {4{ref_clk}}, "R3 bank A carries reference", a_clk, {4{ref_clk}});
    end
    tag = "R8";
    sel = 2'b11;
    @(negedge clk);
    chk(a_oe == 1'b0, "R8 relock after passthrough", a_oe, 0);
    repeat (LK) @(negedge clk);
    chk(a_oe == 1'b1, "R8 banks back after relock", a_oe, 1);
    tag = "R6";
    ref_run = 1'b0;
    repeat (TO + 6) @(negedge clk);
    chk(pd == 1'b1, "R6 timeout enters power-down", pd, 1);
    chk({a_oe, b_oe, fb_oe, pll_en} == 4'b0, "R6 all enables off", {a_oe, b_oe, fb_oe, pll_en}, 0);
    chk(a_clk == 4'b0 && fb_clk == 1'b0, "R9 outputs low in power-down", {a_clk, fb_clk}, 0);
    tag = "R7";
    sel = 2'b10;
    ref_run = 1'b1;
    wait_pd(1'b0, 12, took);
    chk(pd == 1'b0, "R7 edge return ends power-down", pd, 0);
    chk(a_oe == 1'b1, "R3 passthrough skips relock", a_oe, 1);
    repeat (8) @(negedge clk);
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule